// File: doc/BRIEF.md
# Down Counter with Early Terminal Flag

This block keeps an 8-bit count that goes down by one on each decrement request and returns to all ones on a load request. It drives a 64-bit output register that takes one of two data words on every clock. The register takes word A when the count stood at zero before that edge, and word B at all other times.

A direct design would decode zero from the count and send that decode to all 64 mux selects, so the path would hold several gate levels and a large fanout. Here the block works out zero one cycle early. On a decrement it checks whether the count is one and stores the answer in a single flag flop. That flop alone drives the wide selector. The result on the output is cycle for cycle the same as the direct zero decode.

Top module: `anticipated_down_counter`

## Requirements
- R1: While reset is asserted, the count reads 0xFF and the 64-bit output reads zero.
- R2: A load request sets the count to 0xFF at the next edge. Load wins over a decrement requested in the same cycle, and after a load the next output capture takes word B.
- R3: A decrement request without load lowers the count by one at the next edge. A decrement from 0x00 gives 0xFF.
- R4: With neither request asserted, the count keeps its value, and so does the zero indication that controls the output selection.
- R5: On every clock edge after reset, the output captures word A if the count was 0x00 just before that edge, and word B otherwise.
- R6: The internal terminal flag is high exactly when the count is 0x00. The output therefore matches a direct zero decode of the count in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Reload the count to all ones; takes priority |
| dec_i | input | 1 | Decrement the count by one |
| data_a_i | input | 64 | Word captured while the count is zero |
| data_b_i | input | 64 | Word captured while the count is nonzero |
| count_o | output | 8 | Present count value |
| data_o | output | 64 | Registered selected word |

## Verification
The hardest state to reach from the ports is a count of zero. It needs 255 decrements with no load in between. A load that arrives together with a decrement while the count is one is even harder to produce, and so is a run of idle cycles that hold the count at zero. Directed sequences step through each of these cases. After that, long random runs with rare loads and frequent decrements pass through zero many times. A direct zero-decode model runs beside the block and compares both outputs in every cycle.

// File: rtl/anticipated_down_counter.sv
module anticipated_down_counter #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              dec_i,
  input  logic [DATA_W-1:0] data_a_i,
  input  logic [DATA_W-1:0] data_b_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [DATA_W-1:0] data_o
);

  localparam logic [CNT_W-1:0] CNT_FULL = '1;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0]  cnt_q;
  logic              term_q;
  logic [DATA_W-1:0] out_q;

  wire next_is_zero = (cnt_q == CNT_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_FULL;
      term_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= CNT_FULL;
      term_q <= 1'b0;
    end else if (dec_i) begin
      cnt_q  <= cnt_q - CNT_ONE;
      term_q <= next_is_zero;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= term_q ? data_a_i : data_b_i;
  end

  assign count_o = cnt_q;
  assign data_o  = out_q;

  // R2
  load_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == CNT_FULL) && !term_q);

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && dec_i) |=> cnt_q == $past(cnt_q) - CNT_ONE);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !dec_i) |=> $stable(cnt_q) && $stable(term_q));

  // R5
  out_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> data_o == ($past(cnt_q) == '0 ? $past(data_a_i) : $past(data_b_i)));

  // R6
  flag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_q == (cnt_q == '0));

endmodule

// File: tb/test_anticipated_down_counter.sv
module test_anticipated_down_counter;
  localparam int CW = 8;
  localparam int DW = 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          load  = 1'b0;
  logic          dec   = 1'b0;
  logic [DW-1:0] a = '0;
  logic [DW-1:0] b = '0;
  logic [CW-1:0] count;
  logic [DW-1:0] q;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  anticipated_down_counter #(.CNT_W(CW), .DATA_W(DW)) i_anticipated_down_counter (
    .clk(clk), .rst_n(rst_n), .load_i(load), .dec_i(dec),
    .data_a_i(a), .data_b_i(b), .count_o(count), .data_o(q)
  );

  logic [CW-1:0] m_cnt;
  logic [DW-1:0] m_q;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= '1;
      m_q   <= '0;
    end else begin
      m_q <= (m_cnt == '0) ? a : b;
      if (load)     m_cnt <= '1;
      else if (dec) m_cnt <= m_cnt - 1'b1;
    end
  end

  function automatic logic [DW-1:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit ld, input bit dc);
    load = ld; dec = dc; a = rnd64(); b = rnd64();
    @(negedge clk);
    check("R6 count vs direct model", DW'(count), DW'(m_cnt));
    check("R6 output vs direct model", q, m_q);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset count", DW'(count), DW'(8'hFF));
    check("R1 reset output", q, '0);
    rst_n = 1'b1;

    step(1, 0);
    check("R2 load count", DW'(count), DW'(8'hFF));
    for (int i = 0; i < 254; i++) step(0, 1);
    check("R3 count reaches one", DW'(count), DW'(8'h01));
    step(1, 1);
    check("R2 load beats decrement", DW'(count), DW'(8'hFF));
    step(0, 0);
    check("R2 capture after load takes B", q, b);
    for (int i = 0; i < 255; i++) step(0, 1);
    check("R3 count reaches zero", DW'(count), DW'(8'h00));
    for (int i = 0; i < 3; i++) begin
      step(0, 0);
      check("R4 idle holds zero", DW'(count), DW'(8'h00));
      check("R5 zero count selects A", q, a);
    end
    step(0, 1);
    check("R3 wrap from zero", DW'(count), DW'(8'hFF));
    check("R5 last zero capture A", q, a);
    step(0, 0);
    check("R5 nonzero selects B", q, b);
    step(0, 0);
    check("R4 idle holds count", DW'(count), DW'(8'hFF));

    for (int i = 0; i < 6000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      step(r < 2, r >= 20);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule